// File: doc/BRIEF.md
# Fault Status and Address Capture Register Bank

This block is a small register bank that records processor fault events for later inspection by fault-handling software. A hard-fault status word holds two sticky flags: one marks a fault that had to be escalated because it could not be taken at its own configurable priority, and one marks a bus error seen while fetching a vector table entry during exception processing. Each flag stays set until software writes a 1 to its bit, so no event can be lost between two reads.

Two 32-bit address registers, each with its own valid flag, keep the address behind the first memory-protection fault and the first bus fault. Both kinds of fault event arrive with two addresses: the address the instruction asked for and the address of the aligned piece of a split access that actually failed. The protection register keeps the failing piece's address. The bus register keeps the requested address. Once a register is valid, it is locked against later faults until software clears its valid flag.

Software uses a plain register port. A request carries a byte offset, a write strobe and write data. A read returns its data, together with a response strobe, one cycle after the request.

Top module: `fault_capture_regs`

## Requirements
- R1: After a synchronous active-low reset, all flags, both valid bits and both address registers are 0, and `rsp_valid` is low.
- R2: A pulse on `escalate_evt` sets status bit 30 (status word at offset 0x00). The bit stays 1 until a write to 0x00 with data bit 30 at 1. A write with bit 30 at 0 leaves it unchanged.
- R3: A pulse on `vec_fetch_err_evt` sets status bit 1. The bit stays 1 until a write to 0x00 with data bit 1 at 1. A write with bit 1 at 0 leaves it unchanged.
- R4: In the status word, bit 31, bits 29:2 and bit 0 always read as 0. A write of 1 to bit 31 has no effect.
- R5: On `prot_fault_evt` while valid bit 0 (offset 0x0C) is clear, the protection address register (offset 0x04) loads `fault_sub_addr`, and valid bit 0 becomes 1.
- R6: On `bus_fault_evt` while valid bit 1 (offset 0x0C) is clear, the bus address register (offset 0x08) loads `fault_req_addr`, and valid bit 1 becomes 1.
- R7: While a valid bit is set, later fault events of its kind leave the held address unchanged. Writing 1 to valid bit 0 or bit 1 at offset 0x0C clears that bit. Writes to 0x04 and 0x08 have no effect.
- R8: When a fault event and a software clear of the same flag fall in the same cycle, the flag ends up at 1. For an address register, the new address is also loaded in that cycle.
- R9: A read request returns the register contents as they were in the request cycle, with `rsp_valid` high for exactly the following cycle. Offsets other than 0x00, 0x04, 0x08 and 0x0C read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 6 | Byte offset of the register |
| req_wdata | input | 32 | Write data (1 bits clear flags) |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| escalate_evt | input | 1 | Escalated fault event pulse |
| vec_fetch_err_evt | input | 1 | Vector fetch bus error pulse |
| prot_fault_evt | input | 1 | Memory-protection fault pulse |
| bus_fault_evt | input | 1 | Bus fault pulse |
| fault_req_addr | input | 32 | Address requested by the faulting instruction |
| fault_sub_addr | input | 32 | Address of the aligned sub-access that faulted |

## Verification
The coincident case covers a fault event and a software write-one-to-clear that target the same flag or valid bit in the same cycle. The bench provokes it by driving the event pulse and the clearing write in one cycle, for both a status flag and the bus valid bit, with a different address than the one held. It then reads the register back and expects the flag still set. For the bus register, it also expects the newly presented address in place of the old one.

// File: rtl/fault_regs_pkg.sv
`timescale 1ns/1ps
// fault_regs_pkg
// Shared constants for the fault capture register bank: register offsets,
// status bit positions and the flag indices used between submodules.
// Assumes a 32-bit data path and byte offsets on the register port.
package fault_regs_pkg;

    localparam int DATA_W = 32;

    // Register byte offsets
    localparam logic [5:0] OFF_STATUS = 6'h00;
    localparam logic [5:0] OFF_PROT   = 6'h04;
    localparam logic [5:0] OFF_BUS    = 6'h08;
    localparam logic [5:0] OFF_VALID  = 6'h0C;

    // Status word bit positions decoded by software
    localparam int BIT_ESCALATE = 30;
    localparam int BIT_VECFETCH = 1;

    // Index of each sticky flag inside the flag bank
    localparam int IDX_VECFETCH = 0;
    localparam int IDX_ESCALATE = 1;
    localparam int NUM_FLAGS    = 2;

    // Index of each address capture slot
    localparam int SLOT_PROT = 0;
    localparam int SLOT_BUS  = 1;
    localparam int NUM_SLOTS = 2;

    // Bits of the status word that may ever be non-zero
    localparam logic [DATA_W-1:0] STATUS_LIVE_MASK =
        (32'h1 << BIT_ESCALATE) | (32'h1 << BIT_VECFETCH);

endpackage

// File: rtl/fault_sticky_bank.sv
`timescale 1ns/1ps
// fault_sticky_bank
// A row of sticky flags. Each flag is set by a one-cycle event pulse and
// cleared by a one-cycle clear strobe. A set in the same cycle as a clear
// wins, so an event is never dropped.
// Assumes set and clear strobes are synchronous to clk.
module fault_sticky_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold, set or clear one flag; set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_i[i]) begin
                flag_q[i] <= 1'b0;
            end
        end

        // R8: an event always leaves the flag set
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_q[i]);

        // R2/R3: a set flag with no clear stays set
        a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_i[i]) |=> flag_q[i]);

        // R2/R3: a flag rises only because of an event
        a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_q[i] && !set_i[i]) |=> !flag_q[i]);
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/fault_addr_capture.sv
`timescale 1ns/1ps
// fault_addr_capture
// One fault address slot with a valid flag. The slot loads the presented
// address on an event while it is empty, and then holds it until software
// clears the valid flag. An event in the same cycle as a clear reloads it.
// Assumes the caller has already chosen which address feeds this slot.
module fault_addr_capture #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic              clr_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic              valid_q;
    logic [ADDR_W-1:0] addr_q;
    logic              load;

    // A load is allowed when the slot is empty or is being emptied now
    assign load = evt_i && (!valid_q || clr_i);

    // Capture the address, or drop the valid flag on a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            addr_q  <= src_addr_i;
        end else if (clr_i) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;
    assign addr_o  = addr_q;

    // R5/R6: an event into an empty slot records the presented address
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !valid_q) |=> (valid_q && addr_q == $past(src_addr_i)));

    // R7: a full slot with no clear keeps its address
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !clr_i) |=> (valid_q && $stable(addr_q)));

    // R8: event together with clear reloads the slot
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && clr_i) |=> (valid_q && addr_q == $past(src_addr_i)));

endmodule

// File: rtl/fault_reg_port.sv
`timescale 1ns/1ps
// fault_reg_port
// Register port decode. Turns writes into one-cycle clear strobes for the
// sticky flags and valid bits, and returns read data one cycle after a read
// request from a registered mux.
// Assumes one request per cycle and byte offsets matching the package.
module fault_reg_port
    import fault_regs_pkg::*;
#(
    parameter int OFF_W   = 6,
    parameter int ADDR_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [OFF_W-1:0]     req_offset,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [NUM_FLAGS-1:0] flag_i,
    input  logic [NUM_SLOTS-1:0] valid_i,
    input  logic [ADDR_W-1:0]    prot_addr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    output logic [NUM_FLAGS-1:0] clr_flag_o,
    output logic [NUM_SLOTS-1:0] clr_valid_o,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata
);

    logic              wr_status;
    logic              wr_valid;
    logic              rd_req;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    // Only listed bits of the write data act; the rest are ignored
    assign unused_wdata = ^req_wdata;

    assign wr_status = req_valid && req_write && (req_offset == OFF_W'(OFF_STATUS));
    assign wr_valid  = req_valid && req_write && (req_offset == OFF_W'(OFF_VALID));
    assign rd_req    = req_valid && !req_write;

    // Write-one-to-clear strobes for the status flags
    always_comb begin
        clr_flag_o               = '0;
        clr_flag_o[IDX_VECFETCH] = wr_status && req_wdata[BIT_VECFETCH];
        clr_flag_o[IDX_ESCALATE] = wr_status && req_wdata[BIT_ESCALATE];
    end

    // Write-one-to-clear strobes for the valid bits
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            clr_valid_o[s] = wr_valid && req_wdata[s];
        end
    end

    // Assemble the status word; reserved and debug bits stay 0
    always_comb begin
        status_word               = '0;
        status_word[BIT_VECFETCH] = flag_i[IDX_VECFETCH];
        status_word[BIT_ESCALATE] = flag_i[IDX_ESCALATE];
    end

    // Select read data by offset; unknown offsets give 0
    always_comb begin
        rd_mux = '0;
        if (req_offset == OFF_W'(OFF_STATUS)) begin
            rd_mux = status_word;
        end else if (req_offset == OFF_W'(OFF_PROT)) begin
            rd_mux = DATA_W'(prot_addr_i);
        end else if (req_offset == OFF_W'(OFF_BUS)) begin
            rd_mux = DATA_W'(bus_addr_i);
        end else if (req_offset == OFF_W'(OFF_VALID)) begin
            rd_mux = DATA_W'(valid_i);
        end
    end

    // Register the read response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_rdata <= rd_req ? rd_mux : '0;
        end
    end

    // R9: a read request is answered in the next cycle
    a_r9_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);

    // R9: no response without a read request
    a_r9_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);

    // R4: reserved status bits read back as 0
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_offset == OFF_W'(OFF_STATUS)) |=>
            ((rsp_rdata & ~STATUS_LIVE_MASK) == '0));

endmodule

// File: rtl/fault_capture_regs.sv
`timescale 1ns/1ps
// fault_capture_regs
// Top of the fault capture register bank. It holds sticky hard-fault flags
// (escalation, vector fetch error) and two fault address slots: the
// protection slot keeps the faulting sub-access address and the bus slot
// keeps the address the instruction requested.
// Assumes event pulses last one cycle and are synchronous to clk.
module fault_capture_regs
    import fault_regs_pkg::*;
#(
    parameter int OFF_W  = 6,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              escalate_evt,
    input  logic              vec_fetch_err_evt,
    input  logic              prot_fault_evt,
    input  logic              bus_fault_evt,
    input  logic [ADDR_W-1:0] fault_req_addr,
    input  logic [ADDR_W-1:0] fault_sub_addr
);

    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_SLOTS-1:0] slot_evt;
    logic [NUM_SLOTS-1:0] slot_clr;
    logic [NUM_SLOTS-1:0] slot_valid;
    logic [ADDR_W-1:0]    slot_src  [NUM_SLOTS];
    logic [ADDR_W-1:0]    slot_addr [NUM_SLOTS];

    // Route fault pulses to their sticky flags
    always_comb begin
        flag_set               = '0;
        flag_set[IDX_VECFETCH] = vec_fetch_err_evt;
        flag_set[IDX_ESCALATE] = escalate_evt;
    end

    // Route address events and pick each slot's address source
    always_comb begin
        slot_evt            = '0;
        slot_evt[SLOT_PROT] = prot_fault_evt;
        slot_evt[SLOT_BUS]  = bus_fault_evt;
        slot_src[SLOT_PROT] = fault_sub_addr;
        slot_src[SLOT_BUS]  = fault_req_addr;
    end

    fault_sticky_bank #(
        .N (NUM_FLAGS)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .flag_o (flags)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        fault_addr_capture #(
            .ADDR_W (ADDR_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (slot_evt[s]),
            .src_addr_i (slot_src[s]),
            .clr_i      (slot_clr[s]),
            .valid_o    (slot_valid[s]),
            .addr_o     (slot_addr[s])
        );
    end

    fault_reg_port #(
        .OFF_W  (OFF_W),
        .ADDR_W (ADDR_W)
    ) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_offset  (req_offset),
        .req_wdata   (req_wdata),
        .flag_i      (flags),
        .valid_i     (slot_valid),
        .prot_addr_i (slot_addr[SLOT_PROT]),
        .bus_addr_i  (slot_addr[SLOT_BUS]),
        .clr_flag_o  (flag_clr),
        .clr_valid_o (slot_clr),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );

    // R5: the protection slot takes the faulting sub-access address
    a_r5_prot_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_fault_evt && !slot_valid[SLOT_PROT]) |=>
            (slot_addr[SLOT_PROT] == $past(fault_sub_addr)));

    // R6: the bus slot takes the requested address
    a_r6_bus_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fault_evt && !slot_valid[SLOT_BUS]) |=>
            (slot_addr[SLOT_BUS] == $past(fault_req_addr)));

endmodule

// File: tb/fault_capture_regs_bench.sv
`timescale 1ns/1ps
// fault_capture_regs_bench
// Scoreboard bench: the driver pushes expected read data into a queue from
// a reference model, and a monitor pops and compares on each response.
module fault_capture_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        escalate_evt = 1'b0;
    logic        vec_fetch_err_evt = 1'b0;
    logic        prot_fault_evt = 1'b0;
    logic        bus_fault_evt = 1'b0;
    logic [31:0] fault_req_addr = '0;
    logic [31:0] fault_sub_addr = '0;

    int tests = 0;
    int fails = 0;

    // Reference model state
    logic        m_esc = 0, m_vec = 0, m_pv = 0, m_bv = 0;
    logic [31:0] m_pa = 0, m_ba = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    string       cur_tag = "";

    always #2.5 clk = ~clk;

    fault_capture_regs u_fault_capture_regs (
        .clk               (clk),
        .rst_n             (rst_n),
        .req_valid         (req_valid),
        .req_write         (req_write),
        .req_offset        (req_offset),
        .req_wdata         (req_wdata),
        .rsp_valid         (rsp_valid),
        .rsp_rdata         (rsp_rdata),
        .escalate_evt      (escalate_evt),
        .vec_fetch_err_evt (vec_fetch_err_evt),
        .prot_fault_evt    (prot_fault_evt),
        .bus_fault_evt     (bus_fault_evt),
        .fault_req_addr    (fault_req_addr),
        .fault_sub_addr    (fault_sub_addr)
    );

    function automatic logic [31:0] model_read(logic [5:0] off);
        case (off)
            6'h00:   return {1'b0, m_esc, 28'b0, m_vec, 1'b0};
            6'h04:   return m_pa;
            6'h08:   return m_ba;
            6'h0C:   return {30'b0, m_bv, m_pv};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock of stimulus: model follows the rules at the edge
    task automatic step();
        logic clr_pv, clr_bv, clr_e, clr_v;
        @(posedge clk);
        if (req_valid && !req_write) begin
            exp_q.push_back(model_read(req_offset));
            tag_q.push_back(cur_tag);
        end
        clr_e  = req_valid && req_write && req_offset == 6'h00 && req_wdata[30];
        clr_v  = req_valid && req_write && req_offset == 6'h00 && req_wdata[1];
        clr_pv = req_valid && req_write && req_offset == 6'h0C && req_wdata[0];
        clr_bv = req_valid && req_write && req_offset == 6'h0C && req_wdata[1];
        if (escalate_evt) m_esc = 1; else if (clr_e) m_esc = 0;
        if (vec_fetch_err_evt) m_vec = 1; else if (clr_v) m_vec = 0;
        if (prot_fault_evt && (!m_pv || clr_pv)) begin
            m_pv = 1; m_pa = fault_sub_addr;
        end else if (clr_pv) m_pv = 0;
        if (bus_fault_evt && (!m_bv || clr_bv)) begin
            m_bv = 1; m_ba = fault_req_addr;
        end else if (clr_bv) m_bv = 0;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_offset = 0; req_wdata = 0;
        escalate_evt = 0; vec_fetch_err_evt = 0;
        prot_fault_evt = 0; bus_fault_evt = 0;
    endtask

    task automatic rd(input logic [5:0] off, input string tag);
        cur_tag = tag;
        req_valid = 1; req_write = 0; req_offset = off;
        step();
    endtask

    task automatic wr(input logic [5:0] off, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_offset = off; req_wdata = d;
        step();
    endtask

    // Monitor: compare each response against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected response", rsp_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_rdata === e, t, rsp_rdata, e);
            end
        end
    end

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog expired", 32'h0, 32'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0, "R1 rsp_valid low in reset", {31'b0, rsp_valid}, 0);
        rst_n = 1;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R1 rsp_valid low after reset", {31'b0, rsp_valid}, 0);
        rd(6'h00, "R1 status reset");
        rd(6'h04, "R1 prot addr reset");
        rd(6'h08, "R1 bus addr reset");
        rd(6'h0C, "R1 valid reset");

        // R2 escalation flag
        escalate_evt = 1; step();
        rd(6'h00, "R2 escalation set");
        wr(6'h00, 32'h0000_0000);
        rd(6'h00, "R2 write 0 keeps flag");
        wr(6'h00, 32'hC000_0000);
        rd(6'h00, "R2 cleared, R4 bit31 write ignored");

        // R3 vector fetch flag
        vec_fetch_err_evt = 1; step();
        wr(6'h00, 32'h4000_0000);
        rd(6'h00, "R3 vector flag survives other clear");
        wr(6'h00, 32'h0000_0002);
        rd(6'h00, "R3 vector flag cleared");

        // R4 reserved bits with all flags set and all-ones write
        escalate_evt = 1; vec_fetch_err_evt = 1; step();
        wr(6'h00, 32'h8000_0001);
        rd(6'h00, "R4 reserved bits zero");
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, "R4 all-ones write clears live bits");

        // R5 protection slot keeps sub-access address
        prot_fault_evt = 1; fault_req_addr = 32'h0000_1003;
        fault_sub_addr = 32'h0000_1004; step();
        rd(6'h04, "R5 prot addr is sub-access");
        rd(6'h0C, "R5 prot valid");

        // R6 bus slot keeps requested address
        bus_fault_evt = 1; fault_req_addr = 32'h0000_2001;
        fault_sub_addr = 32'h0000_2004; step();
        rd(6'h08, "R6 bus addr is requested");
        rd(6'h0C, "R6 both valid");

        // R7 locked while valid, writes to address registers ignored
        prot_fault_evt = 1; bus_fault_evt = 1;
        fault_req_addr = 32'hDEAD_0000; fault_sub_addr = 32'hBEEF_0000; step();
        wr(6'h04, 32'h1234_5678);
        wr(6'h08, 32'h8765_4321);
        rd(6'h04, "R7 prot addr held");
        rd(6'h08, "R7 bus addr held");
        wr(6'h0C, 32'h0000_0001);
        rd(6'h0C, "R7 prot valid cleared");
        rd(6'h04, "R7 prot addr kept after clear");
        prot_fault_evt = 1; fault_sub_addr = 32'h0000_3008; step();
        rd(6'h04, "R7 prot reload after clear");

        // R8 coincident event and clear
        escalate_evt = 1;
        req_valid = 1; req_write = 1; req_offset = 6'h00; req_wdata = 32'h4000_0000;
        step();
        rd(6'h00, "R8 flag set wins over clear");
        bus_fault_evt = 1; fault_req_addr = 32'h0000_4444;
        fault_sub_addr = 32'h0000_4448;
        req_valid = 1; req_write = 1; req_offset = 6'h0C; req_wdata = 32'h0000_0002;
        step();
        rd(6'h0C, "R8 bus valid kept");
        rd(6'h08, "R8 bus addr reloaded");

        // R9 read returns pre-edge state, unmapped offsets, back-to-back
        cur_tag = "R9 read beside event sees old state";
        req_valid = 1; req_write = 0; req_offset = 6'h00;
        vec_fetch_err_evt = 1; step();
        rd(6'h00, "R9 event visible next read");
        rd(6'h10, "R9 unmapped offset reads 0");
        rd(6'h3C, "R9 unmapped high offset reads 0");
        rd(6'h02, "R9 misaligned offset reads 0");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 every read answered",
              exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule